// File: doc/BRIEF.md
# Half-Turn Slice Buffer Rotation Controller

This block owns the bookkeeping for three equal slice buffers that feed the two halves of a spinning LED panel. Each half-frame slice has to appear twice, once in each panel half on back-to-back half-turns, so that it can be seen from every viewing angle. A buffer index is driven to each display half, and a third index names the spare buffer that neither half is showing. The spare is the only buffer an external DMA engine may write.

On every half-turn boundary pulse the ownership of the three buffers turns like a triangle. The first half takes over the buffer that the second half has just finished showing. The second half takes the freshly filled spare. The buffer that the first half gives up becomes the new spare. After each turn a fill request names the new spare. It stays raised until the DMA engine answers with a one-cycle done pulse. A boundary that arrives while a fill is still open sets a sticky underrun flag, and the rotation goes ahead anyway.

The fill handshake is a two-state machine. PEND means a request is open and IDLE means the spare is full. The transitions are T_RESET (reset, into PEND), T_ROTATE (boundary, from either state into PEND) and T_DONE (done pulse without a boundary, from PEND into IDLE).

Top module: `buf_rot_ctrl`

## Requirements
- R1: After reset the first-half index is 0, the second-half index is 1, the spare and fill index is 2, the fill request is high and the underrun flag is low.
- R2: On the clock edge that samples a boundary pulse, the first-half index takes the old second-half index.
- R3: On that same edge, the second-half index takes the old spare index.
- R4: On that same edge, the spare index takes the old first-half index, and the fill index always equals the spare index.
- R5: The three indices are always distinct, and each one is below 3.
- R6: The fill request is high in the cycle after any boundary pulse. It stays high until a done pulse is sampled with no boundary pulse in the same cycle, and it is low in the cycle after that.
- R7: A done pulse while no request is open has no effect on any output.
- R8: A boundary pulse sampled while the request is open and without a done pulse sets the underrun flag, and the rotation still takes place.
- R9: The underrun flag stays set until a clear pulse is sampled, and it is low in the cycle after the clear. If set and clear arrive in the same cycle, the set wins.
- R10: A boundary pulse and a done pulse in the same cycle do not set underrun, and they leave a new request open.
- R11: Without a boundary pulse, all three indices hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Half-turn boundary pulse |
| fill_done_i | input | 1 | DMA fill-complete pulse |
| underrun_clr_i | input | 1 | Clears the sticky underrun flag |
| half_a_idx_o | output | 2 | Buffer index shown by the first display half |
| half_b_idx_o | output | 2 | Buffer index shown by the second display half |
| fill_req_o | output | 1 | Fill request to the DMA engine |
| fill_idx_o | output | 2 | Buffer to fill (the spare) |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
Every output comes from a register, so each result of a boundary, done or clear pulse appears exactly one clock edge after the pulse is sampled. The bench drives each pulse for one cycle on a falling edge and compares all outputs on the next falling edge, against indices computed as the rotation count modulo 3. The sweep covers every done delay from 0 to 3 cycles across several full rotation periods, done and boundary in the same cycle, stray done pulses, and set and clear in the same cycle.

// File: rtl/buf_rot_pkg.sv
package buf_rot_pkg;
    localparam int IDX_W  = 2;
    localparam int N_BUFS = 3;
    typedef logic [IDX_W-1:0] buf_idx_t;
    typedef enum logic {FILL_IDLE = 1'b0, FILL_PEND = 1'b1} fill_state_e;
endpackage

// File: rtl/buf_rot_ring.sv
module buf_rot_ring
    import buf_rot_pkg::*;
#(
    parameter buf_idx_t RST_A = 2'd0,
    parameter buf_idx_t RST_B = 2'd1,
    parameter buf_idx_t RST_S = 2'd2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rotate_i,
    output buf_idx_t a_o,
    output buf_idx_t b_o,
    output buf_idx_t s_o
);
    buf_idx_t a_q, b_q, s_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= RST_A;
            b_q <= RST_B;
            s_q <= RST_S;
        end else if (rotate_i) begin
            a_q <= b_q;
            b_q <= s_q;
            s_q <= a_q;
        end
    end

    assign a_o = a_q;
    assign b_o = b_q;
    assign s_o = s_q;

    p_a_takes_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rotate_i |=> a_q == $past(b_q));
    p_b_takes_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rotate_i |=> b_q == $past(s_q));
    p_spare_takes_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rotate_i |=> s_q == $past(a_q));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate_i |=> ($stable(a_q) && $stable(b_q) && $stable(s_q)));
endmodule

// File: rtl/buf_rot_fill.sv
module buf_rot_fill
    import buf_rot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rotate_i,
    input  logic done_i,
    output logic req_o
);
    fill_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FILL_PEND;       // T_RESET
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: if (rotate_i) state_d = FILL_PEND;      // T_ROTATE
            FILL_PEND: if (!rotate_i && done_i) state_d = FILL_IDLE; // T_DONE
            default:   state_d = FILL_PEND;
        endcase
    end

    always_comb begin
        req_o = (state_q == FILL_PEND);
    end

    p_req_after_rot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rotate_i |=> req_o);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !done_i) |=> req_o);
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && done_i && !rotate_i) |=> !req_o);
    p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !rotate_i) |=> !req_o);
endmodule

// File: rtl/buf_rot_underrun.sv
module buf_rot_underrun (
    input  logic clk,
    input  logic rst_n,
    input  logic rotate_i,
    input  logic pending_i,
    input  logic done_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;
    logic set_w;

    assign set_w = rotate_i && pending_i && !done_i;

    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_w) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_i && pending_i && !done_i) |=> flag_o);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !rotate_i) |=> !flag_o);
    p_no_false_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(rotate_i && pending_i && !done_i)) |=> !flag_o);
endmodule

// File: rtl/buf_rot_ctrl.sv
module buf_rot_ctrl
    import buf_rot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary_i,
    input  logic       fill_done_i,
    input  logic       underrun_clr_i,
    output logic [1:0] half_a_idx_o,
    output logic [1:0] half_b_idx_o,
    output logic       fill_req_o,
    output logic [1:0] fill_idx_o,
    output logic       underrun_o
);
    buf_idx_t a_w, b_w, s_w;
    logic     req_w;

    buf_rot_ring #(.RST_A(2'd0), .RST_B(2'd1), .RST_S(2'd2)) u_ring (
        .clk(clk), .rst_n(rst_n), .rotate_i(boundary_i),
        .a_o(a_w), .b_o(b_w), .s_o(s_w)
    );

    buf_rot_fill u_fill (
        .clk(clk), .rst_n(rst_n), .rotate_i(boundary_i),
        .done_i(fill_done_i), .req_o(req_w)
    );

    buf_rot_underrun u_unr (
        .clk(clk), .rst_n(rst_n), .rotate_i(boundary_i),
        .pending_i(req_w), .done_i(fill_done_i),
        .clr_i(underrun_clr_i), .flag_o(underrun_o)
    );

    assign half_a_idx_o = a_w;
    assign half_b_idx_o = b_w;
    assign fill_idx_o   = s_w;
    assign fill_req_o   = req_w;

    p_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_a_idx_o != half_b_idx_o) && (half_b_idx_o != fill_idx_o) &&
        (half_a_idx_o != fill_idx_o) &&
        (int'(half_a_idx_o) < N_BUFS) && (int'(half_b_idx_o) < N_BUFS) &&
        (int'(fill_idx_o) < N_BUFS));
endmodule

// File: tb/buf_rot_ctrl_tb.sv
module buf_rot_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boundary_i = 1'b0;
    logic       fill_done_i = 1'b0;
    logic       underrun_clr_i = 1'b0;
    logic [1:0] half_a_idx_o, half_b_idx_o, fill_idx_o;
    logic       fill_req_o, underrun_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    int k = 0;
    logic exp_req = 1'b1;
    logic exp_unr = 1'b0;

    always #2 clk = ~clk;

    buf_rot_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .fill_done_i(fill_done_i), .underrun_clr_i(underrun_clr_i),
        .half_a_idx_o(half_a_idx_o), .half_b_idx_o(half_b_idx_o),
        .fill_req_o(fill_req_o), .fill_idx_o(fill_idx_o),
        .underrun_o(underrun_o)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 100000) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc_cnt);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run = n_run + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 first-half idx"},  half_a_idx_o, k % 3);
        chk({tag, " R3 second-half idx"}, half_b_idx_o, (k + 1) % 3);
        chk({tag, " R4 spare/fill idx"},  fill_idx_o,   (k + 2) % 3);
        chk({tag, " R6 fill_req"},        fill_req_o,   exp_req);
        chk({tag, " R9 underrun"},        underrun_o,   exp_unr);
    endtask

    // one cycle: drive on falling edge, results due on the next falling edge
    task automatic cyc(input logic b, input logic d, input logic c, input string tag);
        logic nreq, nunr;
        nreq = b | (exp_req & ~d);
        nunr = (b & exp_req & ~d) | (exp_unr & ~c);
        boundary_i = b; fill_done_i = d; underrun_clr_i = c;
        @(negedge clk);
        boundary_i = 1'b0; fill_done_i = 1'b0; underrun_clr_i = 1'b0;
        if (b) k = (k + 1) % 3;
        exp_req = nreq;
        exp_unr = nunr;
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        chk("R1 fill_idx after reset", fill_idx_o, 2);
        chk("R1 fill_req after reset", fill_req_o, 1);

        for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R11 idle hold");
        cyc(0, 1, 0, "R6 done drops request");
        cyc(0, 1, 0, "R7 stray done ignored");
        cyc(0, 0, 0, "R7 stray done ignored, after");

        // sweep done delay over several full rotation periods
        for (int r = 0; r < 9; r++) begin
            for (int d = 0; d < 4; d++) begin
                cyc(1, 0, 0, "R2 R3 R4 rotate");
                for (int w = 0; w < d; w++) cyc(0, 0, 0, "R6 request held");
                cyc(0, 1, 0, "R6 fill done");
                cyc(0, 0, 0, "R11 hold after fill");
            end
        end

        // underrun: boundary while a fill is open
        cyc(1, 0, 0, "R8 rotate opens request");
        cyc(1, 0, 0, "R8 rotate while pending");
        cyc(0, 0, 0, "R9 underrun sticky");
        cyc(0, 1, 0, "R9 sticky across done");
        cyc(0, 0, 1, "R9 clear");
        cyc(0, 0, 0, "R9 stays clear");

        // set and clear in the same cycle: set wins
        cyc(1, 0, 0, "R8 rotate");
        cyc(1, 0, 1, "R9 set wins over clear");
        cyc(0, 0, 1, "R9 clear after");

        // boundary and done together: no underrun, new request
        for (int r = 0; r < 4; r++) cyc(1, 1, 0, "R10 boundary with done");
        cyc(0, 1, 0, "R10 final done");
        cyc(1, 0, 0, "R5 rotate");
        cyc(0, 0, 0, "R11 hold");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule